// File: doc/BRIEF.md
# Input-Change Detector and Interrupt Aggregator

This block watches seven general-purpose input pins through a synchroniser. For the four lowest pins it also keeps a sticky flag that records a level change. Software reads those levels and flags together through a change register, and that read clears the flags. An auxiliary control write chooses which pin flags may raise an interrupt. The OR of the enabled flags becomes the top bit of an eight-bit interrupt status byte. The seven lower bits of that byte come straight from transmit, receive, break and counter event lines, which other blocks drive.

A write-only mask byte uses the same bit layout as the status byte. A single active-low interrupt request goes low while any status bit is set together with its mask bit. The register port is a plain synchronous read/write strobe interface. Each offset has one meaning for reads and a different meaning for writes.

Top module: `pin_event_irq`

## Requirements
- R1: A read at offset 4 returns the synchronised levels of pins 0 to 3 in bits 3:0 and their change flags in bits 7:4.
- R2: Each pin passes through two flip-flops. A pin level held before clock edge N appears in read data after edge N+1. The change flag it causes is set by edge N+2.
- R3: A clock edge at which a read of offset 4 is strobed clears all four change flags. A change that is detected at that same edge is still recorded.
- R4: A write at offset 4 loads wdata bits 3:0 as per-pin change-interrupt enables. Status bit 7 is set exactly when some pin has both its change flag and its enable set. Wdata bits 7:4 have no effect.
- R5: A read at offset 5 returns the status byte. Bit 0 is transmit ready A, bit 1 receive ready A, bit 2 break change A, bit 3 counter ready, bit 4 transmit ready B, bit 5 receive ready B and bit 6 break change B; these follow evt_in[6:0] directly. Bit 7 is the input-change summary.
- R6: A write at offset 5 loads the mask byte, which uses the status layout. Reads at offset 5 never return the mask.
- R7: irq_n is 0 exactly when some bit is set in both the status byte and the mask byte.
- R8: A read at offset 13 returns the seven synchronised pin levels in bits 6:0, and bit 7 always reads as 1.
- R9: Writes at any offset other than 4 and 5 change no state. Reads at other offsets, and any cycle without rd_en, return 0.
- R10: After reset all flags, enables and mask bits are 0, and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 7 | Asynchronous general-purpose input pins |
| evt_in | input | 7 | Channel and counter event levels, status bits 6:0 |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets a pin change whose detection lands on the same edge as a clearing read. A design that lets the clear win would lose that event for good. It checks that disabling a pin's enable leaves the flag readable while status bit 7 and irq_n stay quiet, which catches a design that gates the flag itself instead of the summary. It drives writes to the shared offsets and reads back every readable byte. A decoder that confused the read and write meanings, or that let the mask leak into status reads, would show up as a miscompare. The first-cycle latency through the synchroniser is compared edge by edge, so a missing or extra flop shifts every read.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 4;
  localparam int unsigned NPIN   = 7;
  localparam int unsigned NCHG   = 4;
  localparam int unsigned NSYNC  = 2;
  localparam int unsigned PORT_B = DW - 1;

  localparam logic [AW-1:0] OFS_CHG  = AW'(4);
  localparam logic [AW-1:0] OFS_STAT = AW'(5);
  localparam logic [AW-1:0] OFS_RAW  = AW'(13);

  function automatic logic [DW-1:0] pack_change(input logic [NCHG-1:0] flg,
                                                input logic [NCHG-1:0] lvl);
    return {flg, lvl};
  endfunction

  function automatic logic [DW-1:0] pack_raw(input logic [NPIN-1:0] lvl);
    return {1'b1, lvl};
  endfunction

  function automatic logic pending(input logic [DW-1:0] stat,
                                   input logic [DW-1:0] msk);
    return |(stat & msk);
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/chg_flag_bank.sv
module chg_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         clr,
  output logic [N-1:0] diff,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] flag_d;

  assign diff   = lvl ^ prev_q;
  assign flag_d = (clr ? '0 : flag_q) | diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end

  // R3
  chg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diff != '0) |=> ((flag_q & $past(diff)) == $past(diff)));

  // R3
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && diff == '0) |=> (flag_q == '0));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import pin_event_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] evt,
  input  logic          port_any,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask_q,
  output logic          irq_n
);
  assign status = {port_any, evt};
  assign irq_n  = ~pending(status, mask_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata)));

  // R7
  quiet_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n);
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [DW-2:0]   evt_in,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n
);
  logic [NPIN-1:0] pin_lvl;
  logic [NCHG-1:0] chg_diff;
  logic [NCHG-1:0] chg_flag;
  logic [NCHG-1:0] aux_en_q;
  logic [DW-1:0]   status;
  logic [DW-1:0]   mask_q;
  logic            rd_chg;
  logic            wr_aux;
  logic            wr_mask;
  logic            port_any;

  assign rd_chg   = rd_en && (addr == OFS_CHG);
  assign wr_aux   = wr_en && (addr == OFS_CHG);
  assign wr_mask  = wr_en && (addr == OFS_STAT);
  assign port_any = |(chg_flag & aux_en_q);

  sync_chain #(.W(NPIN), .STAGES(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_lvl)
  );

  chg_flag_bank #(.N(NCHG)) u_flags (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[NCHG-1:0]), .clr(rd_chg),
    .diff(chg_diff), .flag_q(chg_flag)
  );

  irq_merge u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .port_any(port_any),
    .mask_wr(wr_mask), .wdata(wdata), .status(status), .mask_q(mask_q),
    .irq_n(irq_n)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      aux_en_q <= '0;
    else if (wr_aux) aux_en_q <= wdata[NCHG-1:0];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_CHG:  rdata = pack_change(chg_flag, pin_lvl[NCHG-1:0]);
        OFS_STAT: rdata = status;
        OFS_RAW:  rdata = pack_raw(pin_lvl);
        default:  rdata = '0;
      endcase
    end
  end

  // R4
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_en_q == '0) |-> !status[PORT_B]);

  // R8
  raw_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_RAW) |-> rdata[DW-1]);

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  // R1
  flag_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chg && chg_flag != '0) |-> (rdata[DW-1:NCHG] != '0));
endmodule

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
module test_pin_event_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pin_in = '0;
  logic [6:0] evt_in = '0;
  logic [3:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_event_irq i_pin_event_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .evt_in(evt_in), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // behavioural reference: pin history as integers, per-pin flags as an int array
  int hist1 [7];
  int hist2 [7];
  int last  [4];
  int flg   [4];
  int en    [4];
  int msk   [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (hist1[i]) begin hist1[i] = 0; hist2[i] = 0; end
      foreach (flg[i]) begin last[i] = 0; flg[i] = 0; en[i] = 0; end
      foreach (msk[i]) msk[i] = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        int moved;
        moved = (hist2[i] != last[i]) ? 1 : 0;
        if (rd_en && addr == 4) flg[i] = moved;
        else if (moved == 1) flg[i] = 1;
        last[i] = hist2[i];
      end
      for (int i = 0; i < 7; i++) begin
        hist2[i] = hist1[i];
        hist1[i] = pin_in[i];
      end
      if (wr_en && addr == 4) for (int i = 0; i < 4; i++) en[i] = wdata[i];
      if (wr_en && addr == 5) for (int i = 0; i < 8; i++) msk[i] = wdata[i];
    end
  end

  function automatic logic [7:0] ref_status();
    logic [7:0] s;
    int any;
    any = 0;
    for (int i = 0; i < 4; i++) if (flg[i] == 1 && en[i] == 1) any = 1;
    s = {any[0], evt_in};
    return s;
  endfunction

  function automatic logic ref_irq_n();
    logic [7:0] s;
    s = ref_status();
    for (int i = 0; i < 8; i++) if (s[i] && msk[i] == 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] ref_rdata();
    logic [7:0] r;
    r = '0;
    if (!rd_en) return r;
    if (addr == 4) begin
      for (int i = 0; i < 4; i++) begin
        r[i] = hist2[i][0];
        r[i+4] = flg[i][0];
      end
    end else if (addr == 5) r = ref_status();
    else if (addr == 13) begin
      r[7] = 1'b1;
      for (int i = 0; i < 7; i++) r[i] = hist2[i][0];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %02h expected %02h", tag, $time, got, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!done) begin
      if (!rst_n) begin
        chk("R10 irq_n", {7'd0, irq_n}, 8'h01);
      end else begin
        chk("R7 R6 irq_n", {7'd0, irq_n}, {7'd0, ref_irq_n()});
        case (addr)
          4'd4:    chk("R1 R2 R3 change read", rdata, ref_rdata());
          4'd5:    chk("R5 R4 status read", rdata, ref_rdata());
          4'd13:   chk("R8 R2 raw read", rdata, ref_rdata());
          default: chk("R9 other offset", rdata, ref_rdata());
        endcase
      end
    end
  end

  task automatic step(input logic [3:0] a, input logic r, input logic w,
                      input logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(4'd0, 1'b0, 1'b0, 8'h00);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(4_000_000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R10: hold reset, then read back empty state
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    step(4'd4, 1'b1, 1'b0, 8'h00);
    step(4'd5, 1'b1, 1'b0, 8'h00);
    // R4: enable all pins, upper data bits ignored; R6 mask only the port bit
    step(4'd4, 1'b0, 1'b1, 8'hF5);
    step(4'd4, 1'b0, 1'b1, 8'hFF);
    step(4'd5, 1'b0, 1'b1, 8'h80);
    // R2: pin 0 rises, follow it edge by edge
    @(negedge clk); pin_in = 7'h01;
    step(4'd4, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b0, 1'b0, 8'h00);
    step(4'd4, 1'b0, 1'b0, 8'h00);
    step(4'd5, 1'b1, 1'b0, 8'h00);
    // R1 R3: read shows flag, then clears it
    step(4'd4, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    // R3: change detected on the same edge as a clearing read
    @(negedge clk); pin_in = 7'h03; addr = 4'd0; rd_en = 1'b0;
    step(4'd0, 1'b0, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    // R4: disable enables, pin 2 changes, flag set but no summary
    step(4'd4, 1'b0, 1'b1, 8'hF0);
    @(negedge clk); pin_in = 7'h07; wr_en = 1'b0;
    idle(4);
    step(4'd5, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    // R5 R7: event lines with partial masks
    step(4'd5, 1'b0, 1'b1, 8'h2A);
    @(negedge clk); evt_in = 7'h55; wr_en = 1'b0; addr = 4'd5; rd_en = 1'b1;
    @(negedge clk); evt_in = 7'h2A;
    @(negedge clk); evt_in = 7'h08;
    step(4'd5, 1'b0, 1'b1, 8'h08);
    step(4'd5, 1'b1, 1'b0, 8'h00);
    // R9: writes elsewhere change nothing
    step(4'd13, 1'b0, 1'b1, 8'hFF);
    step(4'd12, 1'b0, 1'b1, 8'hFF);
    step(4'd0, 1'b0, 1'b1, 8'hFF);
    step(4'd0, 1'b1, 1'b0, 8'h00);
    step(4'd5, 1'b1, 1'b0, 8'h00);
    step(4'd4, 1'b1, 1'b0, 8'h00);
    // R8: all pins high
    @(negedge clk); pin_in = 7'h7F; wr_en = 1'b0; rd_en = 1'b0;
    idle(3);
    step(4'd13, 1'b1, 1'b0, 8'h00);
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lfsr = nxt(lfsr);
      if (lfsr[3:0] == 4'd0) pin_in = pin_in ^ lfsr[10:4];
      if (lfsr[7:5] == 3'd0) evt_in = lfsr[17:11];
      case (lfsr[20:18])
        3'd0, 3'd1: addr = 4'd4;
        3'd2, 3'd3: addr = 4'd5;
        3'd4:       addr = 4'd13;
        default:    addr = lfsr[24:21];
      endcase
      rd_en = lfsr[25];
      wr_en = lfsr[26] & lfsr[27];
      wdata = lfsr[31:24] ^ lfsr[7:0];
    end
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule